// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel with a small word-addressed register bus. Software programs a reload value and a control word, and the channel then counts down. Each decrement comes after the input clock has been divided by an 8-bit prescale setting plus one. When the count runs out, the channel latches an expiry flag and can raise an interrupt.

In one-shot mode the channel stops itself after the first expiry. In periodic mode it reloads and keeps going. A reload value of all ones, in periodic mode with the interrupt masked, turns the channel into a free-running counter. Software reads that counter and inverts it to get a count that rises.

The bus has select, write strobe, a 2-bit word address and 32-bit write data. Writes take effect on the clock edge where select and write are both high. Read data is combinational from the address. The map is: word 0 control, word 1 reload value, word 2 live count (read-only), word 3 interrupt status (write 1 to clear).

Top module: `prescaled_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: Control register fields are bit 30 run enable, bit 29 interrupt enable, bits 28:27 mode and bits 7:0 prescale. They read back as written, and every other control bit reads 0.
- R3: With prescale P and the channel enabled, the first decrement lands P+1 clock edges after the enabling write, and later decrements land every P+1 edges.
- R4: The reload register keeps only its low 24 bits, and its upper bits read 0. A reload write while the channel is stopped copies the value into the live count on the same edge.
- R5: A reload write while the channel is running leaves the live count decrementing as before until the next prescaled tick, which loads the new value.
- R6: A tick that finds the live count at 1 or 0, with no reload pending, is an expiry. It sets status bit 0.
- R7: In any mode other than 01 (one-shot), an expiry leaves the live count at 0 and clears the run-enable bit. The count then holds.
- R8: In mode 01 (periodic), an expiry copies the reload value into the live count, and the channel stays enabled.
- R9: `irq` is high exactly while status bit 0 and the interrupt-enable bit are both 1. An expiry with the interrupt disabled sets the flag but leaves `irq` low.
- R10: Writing the status word with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag set. Writing 0x1f also clears it.
- R11: Writing 0 to the control register freezes the live count, and the prescale divider restarts from zero on the next enable.
- R12: With the reload value 0xffffff, periodic mode and prescale 0, the inverted live count masked to 24 bits rises by one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by select |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts prescaled edges exactly after an enabling write. A divider that fires one edge early, or that does not restart after a stop, shows up as a count value read at the wrong cycle. It checks that a one-shot expiry drops the enable bit and parks the count at zero; a design that kept running would show the count wrapping to 0xffffff. It writes the reload value while the channel is running and samples on each side of the next tick, so a design that loads at once or never loads is caught. The status clear is driven with a zero bit, a one bit and the 0x1f pattern, and a wrong write-1-to-clear polarity leaves the flag in the wrong state.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int CNT_W = 24,
  parameter int PSC_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_INIT = 2'd1;
  localparam logic [AW-1:0] A_CNT  = 2'd2;
  localparam logic [AW-1:0] A_STAT = 2'd3;
  localparam int EN_B   = 30;
  localparam int IE_B   = 29;
  localparam int MODE_H = 28;
  localparam int MODE_L = 27;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;

  logic             en_q, ie_q, pend_q, flag_q;
  logic [1:0]       mode_q;
  logic [PSC_W-1:0] psc_q, pre_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic             wr, wr_ctrl, wr_init, wr_stat;
  logic             periodic, tick, expire;

  assign wr       = bus_sel && bus_wr;
  assign wr_ctrl  = wr && bus_addr == A_CTRL;
  assign wr_init  = wr && bus_addr == A_INIT;
  assign wr_stat  = wr && bus_addr == A_STAT;
  assign periodic = mode_q == MODE_PERIODIC;
  assign tick     = en_q && pre_q >= psc_q;
  assign expire   = tick && !pend_q && cnt_q <= CNT_W'(1);
  assign irq      = flag_q && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= '0;
      psc_q  <= '0;
      pre_q  <= '0;
      init_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (!en_q || tick) pre_q <= '0;
      else               pre_q <= pre_q + 1'b1;

      if (wr_init) init_q <= bus_wdata[CNT_W-1:0];

      if (wr_init)   pend_q <= en_q;
      else if (tick) pend_q <= 1'b0;

      if (wr_init && !en_q)     cnt_q <= bus_wdata[CNT_W-1:0];
      else if (tick) begin
        if (pend_q)             cnt_q <= init_q;
        else if (expire)        cnt_q <= periodic ? init_q : '0;
        else                    cnt_q <= cnt_q - 1'b1;
      end

      if (wr_ctrl) begin
        en_q   <= bus_wdata[EN_B];
        ie_q   <= bus_wdata[IE_B];
        mode_q <= bus_wdata[MODE_H:MODE_L];
        psc_q  <= bus_wdata[PSC_W-1:0];
      end else if (expire && !periodic) begin
        en_q <= 1'b0;
      end

      if (expire)                        flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[EN_B]          = en_q;
        bus_rdata[IE_B]          = ie_q;
        bus_rdata[MODE_H:MODE_L] = mode_q;
        bus_rdata[PSC_W-1:0]     = psc_q;
      end
      A_INIT:  bus_rdata[CNT_W-1:0] = init_q;
      A_CNT:   bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata[0]         = flag_q;
    endcase
  end
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 24,
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             periodic,
  input logic [PSC_W-1:0] psc,
  input logic             tick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init,
  input logic             flag,
  input logic             wr_ctrl,
  input logic             wr_init,
  input logic             wr_stat,
  input logic             wdata0
);
  p_first_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && psc != '0) |-> !tick);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !wr_ctrl) |=> (!en && cnt == '0));
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> cnt == $past(init));
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata0 && !expire) |=> !flag);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_init) |=> $stable(cnt));
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .periodic(periodic), .psc(psc_q),
  .tick(tick), .expire(expire), .cnt(cnt_q), .init(init_q), .flag(flag_q),
  .wr_ctrl(wr_ctrl), .wr_init(wr_init), .wr_stat(wr_stat), .wdata0(bus_wdata[0])
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  localparam logic [1:0] CTRL = 2'd0, INIT = 2'd1, CNT = 2'd2, STAT = 2'd3;

  always #4 clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", CTRL, 0);
    rd_check("R1 init", INIT, 0);
    rd_check("R1 cnt", CNT, 0);
    rd_check("R1 stat", STAT, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_fields;
    wr(CTRL, 32'hBFFF_FF5A);
    rd_check("R2 readback", CTRL, 32'h3800_005A);
    wr(CTRL, 0);
    rd_check("R2 cleared", CTRL, 0);
  endtask

  task automatic t_init;
    wr(INIT, 32'hABCD_EF12);
    rd_check("R4 low bits only", INIT, 32'h00CD_EF12);
    rd_check("R4 loads count", CNT, 32'h00CD_EF12);
  endtask

  task automatic t_prescale_stop;
    logic [31:0] v;
    wr(INIT, 10);
    wr(CTRL, 32'h4800_0003);
    wait_cyc(3); rd_check("R3 before first tick", CNT, 10);
    wait_cyc(1); rd_check("R3 first tick", CNT, 9);
    wait_cyc(4); rd_check("R3 second tick", CNT, 8);
    wr(CTRL, 0);
    rd(CNT, v);
    wait_cyc(12); rd_check("R11 frozen", CNT, v);
    wr(CTRL, 32'h4800_0003);
    wait_cyc(3); rd_check("R11 divider restarted", CNT, v);
    wait_cyc(1); rd_check("R11 first tick after restart", CNT, v - 1);
    wr(CTRL, 0);
  endtask

  task automatic t_oneshot;
    wr(STAT, 1);
    wr(INIT, 3);
    wr(CTRL, 32'h6000_0000);
    wait_cyc(2);
    rd_check("R6 no flag yet", STAT, 0);
    rd_check("R6 count 1", CNT, 1);
    wait_cyc(1);
    rd_check("R6 flag set", STAT, 1);
    rd_check("R7 count zero", CNT, 0);
    rd_check("R7 enable cleared", CTRL, 32'h2000_0000);
    check("R9 irq high", {31'b0, irq}, 1);
    wait_cyc(4);
    rd_check("R7 holds", CNT, 0);
    wr(STAT, 32'h2);
    rd_check("R10 zero bit ignored", STAT, 1);
    wr(STAT, 1);
    rd_check("R10 cleared", STAT, 0);
    check("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic;
    wr(INIT, 2);
    wr(CTRL, 32'h4800_0001);
    wait_cyc(3);
    rd_check("R8 count 1", CNT, 1);
    rd_check("R6 periodic no flag", STAT, 0);
    wait_cyc(1);
    rd_check("R8 reloaded", CNT, 2);
    rd_check("R6 periodic flag", STAT, 1);
    check("R9 masked irq", {31'b0, irq}, 0);
    rd_check("R8 still enabled", CTRL, 32'h4800_0001);
    wr(STAT, 32'h1f);
    rd_check("R10 0x1f clears", STAT, 0);
    wait_cyc(2);
    rd_check("R8 second period", CNT, 1);
    wait_cyc(1);
    rd_check("R8 second reload", CNT, 2);
    rd_check("R8 second flag", STAT, 1);
    wr(CTRL, 0);
    wr(STAT, 1);
  endtask

  task automatic t_reload_running;
    wr(INIT, 20);
    wr(CTRL, 32'h4800_0003);
    wait_cyc(4);
    rd_check("R5 pre", CNT, 19);
    wr(INIT, 7);
    rd_check("R5 count unchanged", CNT, 19);
    wait_cyc(2);
    rd_check("R5 before tick", CNT, 19);
    wait_cyc(1);
    rd_check("R5 loaded on tick", CNT, 7);
    wait_cyc(4);
    rd_check("R5 decrements after load", CNT, 6);
    wr(CTRL, 0);
  endtask

  task automatic t_freerun;
    logic [31:0] d;
    wr(INIT, 32'hFFFF_FFFF);
    wr(CTRL, 32'h4800_0000);
    rd(CNT, d);
    check("R12 start", ~d & 32'hFF_FFFF, 0);
    wait_cyc(5);
    rd(CNT, d);
    check("R12 rising", ~d & 32'hFF_FFFF, 5);
    check("R12 irq low", {31'b0, irq}, 0);
    wr(CTRL, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fields;
    t_init;
    t_prescale_stop;
    t_oneshot;
    t_periodic;
    t_reload_running;
    t_freerun;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule